// File: doc/BRIEF.md
# Transition-Limited Parallel Link Coder

This block moves 18-bit words across a narrow parallel link made of six data lines and one flip line, and it bounds the switching activity on those data lines. The transmit half cuts each word into three 6-bit slices and sends them on three consecutive cycles, lowest slice first, with a start line that is high for the first slice. A slice that has more than half of its bits set is complemented, and the flip line says so. The slice is then XORed into the line state, so a data line changes only where the slice has a one. Since a slice never has more than three ones after this step, no more than three of the six data lines switch in any cycle.

The receive half keeps its own copy of the previous line state. It XORs that copy with the incoming lines, undoes the complement when the flip line is high, and rebuilds the word. The encoding leaves some patterns unused, and the receiver uses them as a built-in parity check: too many switching lines, or a flip paired with exactly half the lines switching, raises an error flag. Both halves share one clock and one reset, and their line registers clear to zero together. In use, the transmit outputs drive the link and the far end's receive inputs take the link.

Top module: `tlb_link_codec`

## Requirements
- R1: During reset and right after it, tx_lines, tx_flip, tx_start, dec_valid and dec_err are all zero and enc_ready is 1.
- R2: A word offered with enc_load while enc_ready is 1 is accepted at that clock edge. Its slices bits [5:0], [11:6] and [17:12] appear on the transmit lines after that edge and after the next two edges, in that order. tx_start is 1 only while the first slice is shown.
- R3: tx_flip for a slice is 1 exactly when the slice has four or more ones. The new tx_lines equals the old tx_lines XOR the slice, or XOR the complement of the slice when tx_flip is 1.
- R4: Between any two consecutive cycles, at most three of the six tx_lines change.
- R5: enc_ready is 0 while the second and third slices are still to be sent. enc_load during those cycles is ignored: the word in flight is unchanged and no extra word follows. A new word can be accepted at the edge right after the third slice appears, so words can stream at one per three cycles.
- R6: When no word is being sent, tx_lines keep their value and tx_flip and tx_start are 0.
- R7: The receiver recovers a slice as rx_lines XOR its stored previous line state, complemented when rx_flip is 1. rx_start begins a new word, even in the middle of a word. One cycle after the third slice is sampled, dec_word holds the rebuilt word and dec_valid pulses for one cycle.
- R8: dec_err is 1 for one cycle after a sampled cycle in which more than three data lines changed, or rx_flip was 1 with exactly three lines changed.
- R9: When the transmit outputs drive the receive inputs, every accepted word comes back unchanged on dec_word.
- R10: Line changes that arrive without a word in progress and without rx_start produce no dec_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst_n | input | 1 | Active-low synchronous reset for both halves |
| enc_word | input | 18 | Word to send |
| enc_load | input | 1 | Offer enc_word for sending |
| enc_ready | output | 1 | A word offered now is accepted |
| tx_lines | output | 6 | Transmit data line state |
| tx_flip | output | 1 | Transmit slice was complemented |
| tx_start | output | 1 | Transmit slice is the first of a word |
| rx_lines | input | 6 | Received data line state |
| rx_flip | input | 1 | Received flip line |
| rx_start | input | 1 | Received start line |
| dec_word | output | 18 | Rebuilt word |
| dec_valid | output | 1 | dec_word is new this cycle |
| dec_err | output | 1 | Forbidden line change pattern was seen |

## Verification
The receiver can finish a word and detect a forbidden pattern at the same edge, so dec_valid and dec_err can rise together. The bench provokes this by corrupting the link on the third slice of a word. It either XORs a mask into the received lines or inverts the received flip line at that point. It then expects dec_valid and dec_err in the same cycle. When the mask is removed on the following idle cycle, the receiver sees the mask again as a line change, and the bench judges that cycle's error flag from the mask's bit count.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // Width needed to hold a count from 0 to w inclusive.
   function automatic int unsigned cnt_width(input int unsigned w);
      return $clog2(w + 1);
   endfunction

   // True when the value is a power of two.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tlb_popcount.sv
module tlb_popcount #(
   parameter int unsigned W  = 6,
   parameter int unsigned CW = tlb_pkg::cnt_width(W)
) (
   input  logic [W-1:0]  bits,
   output logic [CW-1:0] cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < int'(W); i++) begin
         cnt = cnt + CW'(bits[i]);
      end
   end
endmodule

// File: rtl/tlb_encoder.sv
module tlb_encoder #(
   parameter int unsigned LANE_W = 6,
   parameter int unsigned NSUB   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LANE_W*NSUB-1:0]   enc_word,
   input  logic                     enc_load,
   output logic                     enc_ready,
   output logic [LANE_W-1:0]        tx_lines,
   output logic                     tx_flip,
   output logic                     tx_start
);
   localparam int unsigned WORD_W = LANE_W * NSUB;
   localparam int unsigned HALF   = LANE_W / 2;
   localparam int unsigned CW     = tlb_pkg::cnt_width(LANE_W);
   localparam int unsigned IDX_W  = $clog2(NSUB);
   // The count's MSB alone decides the flip when HALF+1 is its weight.
   localparam bit MSB_RULE = tlb_pkg::is_pow2(HALF + 1) && ((HALF + 1) == (1 << (CW - 1)));

   logic [LANE_W-1:0] line_q;
   logic              flip_q;
   logic              start_q;
   logic              busy_q;
   logic [IDX_W-1:0]  cnt_q;
   logic [WORD_W-1:0] hold_q;

   logic              take;
   logic              send;
   logic [LANE_W-1:0] cur_sub;
   logic [CW-1:0]     ones;
   logic              flip_n;
   logic [LANE_W-1:0] lane_delta;

   assign take    = !busy_q && enc_load;
   assign send    = busy_q || take;
   assign cur_sub = busy_q ? hold_q[LANE_W-1:0] : enc_word[LANE_W-1:0];

   tlb_popcount #(.W(LANE_W), .CW(CW)) u_ones (
      .bits (cur_sub),
      .cnt  (ones)
   );

   generate
      if (MSB_RULE) begin : g_flip_msb
         assign flip_n = ones[CW-1];
      end else begin : g_flip_cmp
         assign flip_n = (ones > CW'(HALF));
      end
   endgenerate

   assign lane_delta = flip_n ? ~cur_sub : cur_sub;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q  <= '0;
         flip_q  <= 1'b0;
         start_q <= 1'b0;
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         hold_q  <= '0;
      end else if (send) begin
         line_q  <= line_q ^ lane_delta;
         flip_q  <= flip_n;
         start_q <= take;
         if (take) begin
            hold_q <= enc_word >> LANE_W;
            busy_q <= 1'b1;
            cnt_q  <= IDX_W'(1);
         end else begin
            hold_q <= hold_q >> LANE_W;
            if (cnt_q == IDX_W'(NSUB - 1)) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + IDX_W'(1);
            end
         end
      end else begin
         flip_q  <= 1'b0;
         start_q <= 1'b0;
      end
   end

   assign enc_ready = !busy_q;
   assign tx_lines  = line_q;
   assign tx_flip   = flip_q;
   assign tx_start  = start_q;

   // R3: whichever flip variant is built agrees with the count threshold
   a_r3_flip_rule: assert property (@(posedge clk) disable iff (!rst_n)
      flip_n == (ones > CW'(HALF)));

   // R4: the number of switching data lines stays bounded
   a_r4_toggle_limit: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(line_q ^ $past(line_q)) <= int'(HALF));

   // R5: a load seen while busy never starts a word
   a_r5_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy_q) |-> !start_q);

   // R6: idle cycles leave the link quiet
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(busy_q) && !$past(enc_load)) |-> ($stable(line_q) && !flip_q && !start_q));
endmodule

// File: rtl/tlb_decoder.sv
module tlb_decoder #(
   parameter int unsigned LANE_W = 6,
   parameter int unsigned NSUB   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LANE_W-1:0]        rx_lines,
   input  logic                     rx_flip,
   input  logic                     rx_start,
   output logic [LANE_W*NSUB-1:0]   dec_word,
   output logic                     dec_valid,
   output logic                     dec_err
);
   localparam int unsigned WORD_W = LANE_W * NSUB;
   localparam int unsigned HALF   = LANE_W / 2;
   localparam int unsigned CW     = tlb_pkg::cnt_width(LANE_W);
   localparam int unsigned IDX_W  = $clog2(NSUB);

   logic [LANE_W-1:0] prev_q;
   logic [LANE_W-1:0] acc_q [NSUB];
   logic [IDX_W-1:0]  idx_q;
   logic              active_q;
   logic [WORD_W-1:0] word_q;
   logic              valid_q;
   logic              err_q;

   logic [LANE_W-1:0] diff;
   logic [LANE_W-1:0] sub;
   logic [CW-1:0]     tog;
   logic              bad;
   logic [WORD_W-1:0] full;

   assign diff = rx_lines ^ prev_q;
   assign sub  = rx_flip ? ~diff : diff;

   tlb_popcount #(.W(LANE_W), .CW(CW)) u_tog (
      .bits (diff),
      .cnt  (tog)
   );

   // A flipped slice always sends fewer than HALF ones.
   assign bad = (tog > CW'(HALF)) || (rx_flip && (tog == CW'(HALF)));

   always_comb begin
      full = '0;
      for (int i = 0; i < int'(NSUB) - 1; i++) begin
         full[i*LANE_W +: LANE_W] = acc_q[i];
      end
      full[(NSUB-1)*LANE_W +: LANE_W] = sub;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q   <= '0;
         idx_q    <= '0;
         active_q <= 1'b0;
         word_q   <= '0;
         valid_q  <= 1'b0;
         err_q    <= 1'b0;
         for (int i = 0; i < int'(NSUB); i++) begin
            acc_q[i] <= '0;
         end
      end else begin
         prev_q  <= rx_lines;
         err_q   <= bad;
         valid_q <= 1'b0;
         if (rx_start) begin
            acc_q[0] <= sub;
            idx_q    <= IDX_W'(1);
            active_q <= 1'b1;
         end else if (active_q) begin
            acc_q[idx_q] <= sub;
            if (idx_q == IDX_W'(NSUB - 1)) begin
               word_q   <= full;
               valid_q  <= 1'b1;
               active_q <= 1'b0;
               idx_q    <= '0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
            end
         end
      end
   end

   assign dec_word  = word_q;
   assign dec_valid = valid_q;
   assign dec_err   = err_q;

   // R8: too many switching lines always raise the error flag next cycle
   a_r8_err_on_excess: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(rx_lines ^ prev_q) > int'(HALF)) |=> dec_err);

   // R7: a rebuilt word is announced for a single cycle
   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> !dec_valid);

   // R10: no word completes unless assembly was in progress
   a_r10_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !rx_start) |=> !dec_valid);
endmodule

// File: rtl/tlb_link_codec.sv
module tlb_link_codec #(
   parameter int unsigned LANE_W = 6,
   parameter int unsigned NSUB   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [LANE_W*NSUB-1:0]   enc_word,
   input  logic                     enc_load,
   output logic                     enc_ready,
   output logic [LANE_W-1:0]        tx_lines,
   output logic                     tx_flip,
   output logic                     tx_start,
   input  logic [LANE_W-1:0]        rx_lines,
   input  logic                     rx_flip,
   input  logic                     rx_start,
   output logic [LANE_W*NSUB-1:0]   dec_word,
   output logic                     dec_valid,
   output logic                     dec_err
);
   generate
      if ((LANE_W < 2) || (LANE_W % 2 != 0)) begin : g_bad_lane
         $error("LANE_W must be even and at least 2");
      end
      if (NSUB < 2) begin : g_bad_nsub
         $error("NSUB must be at least 2");
      end
   endgenerate

   tlb_encoder #(.LANE_W(LANE_W), .NSUB(NSUB)) u_enc (
      .clk       (clk),
      .rst_n     (rst_n),
      .enc_word  (enc_word),
      .enc_load  (enc_load),
      .enc_ready (enc_ready),
      .tx_lines  (tx_lines),
      .tx_flip   (tx_flip),
      .tx_start  (tx_start)
   );

   tlb_decoder #(.LANE_W(LANE_W), .NSUB(NSUB)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_lines  (rx_lines),
      .rx_flip   (rx_flip),
      .rx_start  (rx_start),
      .dec_word  (dec_word),
      .dec_valid (dec_valid),
      .dec_err   (dec_err)
   );
endmodule

// File: tb/tlb_link_codec_test.sv
module tlb_link_codec_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [17:0] enc_word;
   logic        enc_load;
   logic        enc_ready;
   logic [5:0]  tx_lines;
   logic        tx_flip;
   logic        tx_start;
   logic [17:0] dec_word;
   logic        dec_valid;
   logic        dec_err;

   logic [5:0]  inj_mask;
   logic        inj_flip;
   logic        inj_start;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [5:0]  exp_line;
   bit          pending;
   logic [17:0] pend_w;
   bit          pend_valid;
   bit          pend_clean;
   bit          pend_err;
   bit          undo_err;

   always #4 clk = ~clk;

   tlb_link_codec uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .enc_word  (enc_word),
      .enc_load  (enc_load),
      .enc_ready (enc_ready),
      .tx_lines  (tx_lines),
      .tx_flip   (tx_flip),
      .tx_start  (tx_start),
      .rx_lines  (tx_lines ^ inj_mask),
      .rx_flip   (tx_flip ^ inj_flip),
      .rx_start  (tx_start | inj_start),
      .dec_word  (dec_word),
      .dec_valid (dec_valid),
      .dec_err   (dec_err)
   );

   function automatic int popc6(input logic [5:0] v);
      int n = 0;
      for (int i = 0; i < 6; i++) n += int'(v[i]);
      return n;
   endfunction

   function automatic bit dec_bad(input logic [5:0] d, input bit f);
      return (popc6(d) > 3) || (f && popc6(d) == 3);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Called at a negedge after the decoder sampled the third slice.
   task automatic check_pending();
      chk(dec_valid == pend_valid, "R7 dec_valid at word end", 32'(dec_valid), 32'(pend_valid));
      if (pend_valid && pend_clean)
         chk(dec_word == pend_w, "R9 round trip word", 32'(dec_word), 32'(pend_w));
      chk(dec_err == pend_err, "R8 dec_err at word end", 32'(dec_err), 32'(pend_err));
      inj_mask = '0;
      inj_flip = 1'b0;
      pending  = 1'b0;
   endtask

   // Starts and ends at a negedge.
   task automatic send_word(input logic [17:0] w, input logic [5:0] mask,
                            input bit flinj, input bit stinj, input bit spur);
      logic [5:0] s;
      logic [5:0] d;
      bit f;
      enc_word = w;
      enc_load = 1'b1;
      @(posedge clk);
      @(negedge clk);
      enc_load = spur;
      if (spur) enc_word = ~w;
      if (pending) check_pending();
      for (int i = 0; i < 3; i++) begin
         if (i > 0) begin
            @(posedge clk);
            @(negedge clk);
         end
         s = w[i*6 +: 6];
         f = popc6(s) > 3;
         d = f ? ~s : s;
         exp_line = exp_line ^ d;
         chk(tx_lines == exp_line, "R2 R3 slice lines", 32'(tx_lines), 32'(exp_line));
         chk(tx_flip == f, "R3 flip decision", 32'(tx_flip), 32'(f));
         chk(tx_start == (i == 0), "R2 start strobe", 32'(tx_start), 32'(i == 0));
         chk(enc_ready == (i == 2), "R5 ready timing", 32'(enc_ready), 32'(i == 2));
         if (i == 1) inj_start = stinj;
         if (i == 2) begin
            enc_load   = 1'b0;
            inj_start  = 1'b0;
            inj_mask   = mask;
            inj_flip   = flinj;
            pend_err   = dec_bad(d ^ mask, f ^ flinj);
            undo_err   = popc6(mask) > 3;
         end
      end
      pending    = 1'b1;
      pend_w     = w;
      pend_valid = !stinj;
      pend_clean = (mask == '0) && !flinj;
   endtask

   task automatic finish_pending();
      @(posedge clk);
      @(negedge clk);
      check_pending();
      @(posedge clk);
      @(negedge clk);
      chk(dec_valid == 1'b0, "R10 no valid when idle", 32'(dec_valid), 32'd0);
      chk(dec_err == undo_err, "R8 mask removal", 32'(dec_err), 32'(undo_err));
      chk(tx_lines == exp_line, "R6 R5 lines hold, no extra word", 32'(tx_lines), 32'(exp_line));
      chk(!tx_flip && !tx_start, "R6 flip and start idle", {30'd0, tx_flip, tx_start}, 32'd0);
      undo_err = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      rst_n     = 1'b0;
      enc_word  = '0;
      enc_load  = 1'b0;
      inj_mask  = '0;
      inj_flip  = 1'b0;
      inj_start = 1'b0;
      exp_line  = '0;
      pending   = 1'b0;
      undo_err  = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(tx_lines == '0 && !tx_flip && !tx_start, "R1 reset lines", {24'd0, tx_lines, tx_flip, tx_start}, 32'd0);
      chk(enc_ready == 1'b1, "R1 reset ready", 32'(enc_ready), 32'd1);
      chk(!dec_valid && !dec_err, "R1 reset decoder flags", {30'd0, dec_valid, dec_err}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(tx_lines == '0 && enc_ready, "R1 after reset", {25'd0, tx_lines, enc_ready}, 32'd1);

      // Directed patterns: all zero, all one, threshold slices.
      send_word(18'h00000, '0, 1'b0, 1'b0, 1'b0);
      send_word(18'h3FFFF, '0, 1'b0, 1'b0, 1'b0);
      send_word({6'b001111, 6'b000111, 6'b101010}, '0, 1'b0, 1'b0, 1'b0);
      send_word({6'b111000, 6'b011111, 6'b110000}, '0, 1'b0, 1'b0, 1'b0);
      finish_pending();

      // R5: loads during a word in flight are ignored.
      send_word(18'h2A5C3, '0, 1'b0, 1'b0, 1'b1);
      finish_pending();

      // Word end and error in the same cycle: mask on the third slice (R8).
      send_word({6'b000000, 6'b110011, 6'b010101}, 6'b001111, 1'b0, 1'b0, 1'b0);
      finish_pending();
      // Flip line inverted on a three-ones slice: parity rule (R8).
      send_word({6'b010101, 6'b000001, 6'b100000}, '0, 1'b1, 1'b0, 1'b0);
      finish_pending();
      // Mild mask with no error expected.
      send_word({6'b000000, 6'b000000, 6'b000000}, 6'b000011, 1'b0, 1'b0, 1'b0);
      finish_pending();

      // R7: a start mid-word restarts assembly, so no word completes.
      send_word(18'h1B2C4, '0, 1'b0, 1'b1, 1'b0);
      send_word(18'h0F0F0, '0, 1'b0, 1'b0, 1'b0);
      finish_pending();

      // R10: line changes with no word in progress.
      inj_mask = 6'b000011;
      @(posedge clk);
      @(negedge clk);
      inj_mask = '0;
      chk(dec_valid == 1'b0 && dec_err == 1'b0, "R10 stray change", {30'd0, dec_valid, dec_err}, 32'd0);
      @(posedge clk);
      @(negedge clk);
      chk(dec_valid == 1'b0 && dec_err == 1'b0, "R10 stray change removed", {30'd0, dec_valid, dec_err}, 32'd0);

      // Constrained random words, mixed streaming and gaps.
      for (int n = 0; n < 400; n++) begin
         logic [17:0] w;
         w = 18'($urandom);
         send_word(w, '0, 1'b0, 1'b0, ($urandom % 8) == 0);
         if (($urandom % 2) == 0) finish_pending();
      end
      if (pending) finish_pending();

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule